// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block sits on a two-wire serial bus as a slave and fronts a small byte-addressed memory. It oversamples the clock and data lines with the system clock, finds START, repeated START and STOP conditions, matches a 7-bit device address and pulls the data line low through an open-drain enable. The data line is never driven high. A single internal pointer selects the location to access. Every byte read or written moves the pointer one location further.

A write frame carries one byte address and then any number of data bytes. A write frame that stops after its address byte only loads the pointer. This lets the master set the position for a later read. Three read styles are served:
- **Current-position read:** a read frame returns the byte under the pointer.
- **Random read:** an address-only write, then a repeated START, then a read frame.
- **Sequential read:** the slave keeps sending while the master acknowledges each byte.

Writes wrap inside a page. Reads wrap over the whole memory. After reset the memory is erased and every location reads 8'hFF.

Top module: `i2c_mem_slave`

## Requirements
- R1: While reset is asserted `sda_oe` is 0. After reset every memory location reads back as 8'hFF.
- R2: The slave pulls SDA low in the ninth clock only when the first byte after a START carries the device address in bits 7..1 (7'h50 by default; bit 0 is R/W, 1 = read). On a mismatch it does not acknowledge. Until the next START it drives nothing, stores nothing and leaves the pointer unchanged.
- R3: In a write frame the slave acknowledges the byte address and each data byte. The first byte after the device address loads the pointer. Each following byte is stored at the pointer.
- R4: After each stored byte only the low PAGE_W bits of the pointer step (default 4, a 16-byte page). Writing past the page's last byte continues at the first byte of the same page.
- R5: A read frame with no address phase first returns the byte at the pointer, which is one location past the last byte read or written.
- R6: A write frame that holds only a byte address, followed by a repeated START and a read frame, returns the byte at that address. The repeated START does not change the loaded pointer.
- R7: While the master acknowledges (SDA low in the ninth clock), the slave sends bytes from consecutive addresses, and page boundaries do not stop it.
- R8: During reads the pointer steps over the whole memory, so the byte after location 2^ADDR_W-1 comes from location 0.
- R9: After a not-acknowledge and STOP the slave releases SDA and returns to standby. The next START with a matching address is acknowledged.
- R10: The slave changes SDA only while SCL is low. It releases SDA for the master's acknowledge clock after each byte it sends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset; erases the memory and returns the slave to standby |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull the data line low when 1; release it when 0 |

## Verification
On a single falling edge of SCL, the slave hands the next read byte to its transmit register and advances the pointer. When the pointer is at the last location, that same edge also takes it over the end of memory. The bench provokes this with a random read at 8'hFF that the master acknowledges. It expects the byte stored at 8'hFF and then the byte stored at 8'h00. A second collision happens when a data byte is stored in the last slot of a page. The bench writes a page-crossing burst and reads back the first byte of that page. Each returned byte is popped from a scoreboard queue that a reference model filled.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

   typedef enum logic [3:0] {
      ST_STANDBY,
      ST_DEVADDR,
      ST_ACK_DEV,
      ST_WADDR,
      ST_ACK_WADDR,
      ST_WDATA,
      ST_ACK_WDATA,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } slv_state_e;

   typedef struct packed {
      logic scl;
      logic sda;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_ev_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
   import i2c_mem_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_i,
   input  logic    sda_i,
   output bus_ev_t ev
);

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 1..4");
   end

   logic [SYNC_STAGES-1:0] scl_ch;
   logic [SYNC_STAGES-1:0] sda_ch;
   logic                   scl_q;
   logic                   sda_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ch[0] <= 1'b1;
               sda_ch[0] <= 1'b1;
            end else begin
               scl_ch[0] <= scl_i;
               sda_ch[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ch[i] <= 1'b1;
               sda_ch[i] <= 1'b1;
            end else begin
               scl_ch[i] <= scl_ch[i-1];
               sda_ch[i] <= sda_ch[i-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_ch[SYNC_STAGES-1];
         sda_q <= sda_ch[SYNC_STAGES-1];
      end
   end

   always_comb begin
      ev.scl      = scl_ch[SYNC_STAGES-1];
      ev.sda      = sda_ch[SYNC_STAGES-1];
      ev.scl_rise = ev.scl & ~scl_q;
      ev.scl_fall = ~ev.scl & scl_q;
      ev.start    = ev.scl & scl_q & sda_q & ~ev.sda;
      ev.stop     = ev.scl & scl_q & ~sda_q & ev.sda;
   end

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
   parameter int          ADDR_W = 8,
   parameter int          DATA_W = 8,
   parameter logic [7:0]  ERASED = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   if (DATA_W != 8) begin : g_bad_data
      $error("DATA_W must be 8 for a byte memory");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  vld;

   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld       <= '0;
      else if (wr_en) vld[addr] <= 1'b1;
   end

   assign rd_data = vld[addr] ? mem[addr] : ERASED;

endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
   import i2c_mem_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h50,
   parameter int         ADDR_W   = 8,
   parameter int         PAGE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ev_t           ev,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] ptr_o,
   output logic              wr_en,
   output logic [7:0]        wr_data,
   output logic              sda_oe
);

   slv_state_e        state;
   logic [3:0]        bitcnt;
   logic [7:0]        rx_sh;
   logic [7:0]        tx_sh;
   logic [ADDR_W-1:0] ptr;
   logic [ADDR_W-1:0] ptr_wr_next;
   logic              rw_q;
   logic              mack_q;
   logic              oe_q;
   logic              byte_done;
   logic              addr_hit;
   logic              rd_load;

   if (PAGE_W >= ADDR_W) begin : g_page_whole
      assign ptr_wr_next = ptr + 1'b1;
   end else begin : g_page_part
      assign ptr_wr_next = {ptr[ADDR_W-1:PAGE_W], PAGE_W'(ptr[PAGE_W-1:0] + 1'b1)};
   end

   assign byte_done = ev.scl_fall && (bitcnt == 4'd8);
   assign addr_hit  = (rx_sh[7:1] == DEV_ADDR);
   assign wr_en     = (state == ST_WDATA) && byte_done;
   assign wr_data   = rx_sh;
   assign rd_load   = ev.scl_fall &&
                      (((state == ST_ACK_DEV) && rw_q) || ((state == ST_RACK) && mack_q));
   assign ptr_o     = ptr;
   assign sda_oe    = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_STANDBY;
         bitcnt <= '0;
         rx_sh  <= '0;
         tx_sh  <= '0;
         ptr    <= '0;
         rw_q   <= 1'b0;
         mack_q <= 1'b0;
         oe_q   <= 1'b0;
      end else if (ev.stop) begin
         state <= ST_STANDBY;
         oe_q  <= 1'b0;
      end else if (ev.start) begin
         state  <= ST_DEVADDR;
         bitcnt <= '0;
         oe_q   <= 1'b0;
      end else begin
         unique case (state)
            ST_DEVADDR, ST_WADDR, ST_WDATA: begin
               if (ev.scl_rise && bitcnt < 4'd8) begin
                  rx_sh  <= {rx_sh[6:0], ev.sda};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  if (state == ST_DEVADDR) begin
                     if (addr_hit) begin
                        rw_q  <= rx_sh[0];
                        oe_q  <= 1'b1;
                        state <= ST_ACK_DEV;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end else if (state == ST_WADDR) begin
                     ptr   <= rx_sh[ADDR_W-1:0];
                     oe_q  <= 1'b1;
                     state <= ST_ACK_WADDR;
                  end else begin
                     ptr   <= ptr_wr_next;
                     oe_q  <= 1'b1;
                     state <= ST_ACK_WDATA;
                  end
               end
            end
            ST_ACK_DEV: begin
               if (ev.scl_fall) begin
                  bitcnt <= '0;
                  if (rw_q) begin
                     tx_sh <= rd_data;
                     oe_q  <= ~rd_data[7];
                     ptr   <= ptr + 1'b1;
                     state <= ST_RDATA;
                  end else begin
                     oe_q  <= 1'b0;
                     state <= ST_WADDR;
                  end
               end
            end
            ST_ACK_WADDR, ST_ACK_WDATA: begin
               if (ev.scl_fall) begin
                  oe_q   <= 1'b0;
                  bitcnt <= '0;
                  state  <= ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (ev.scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     oe_q  <= 1'b0;
                     state <= ST_RACK;
                  end else begin
                     tx_sh  <= {tx_sh[6:0], 1'b0};
                     oe_q   <= ~tx_sh[6];
                     bitcnt <= bitcnt + 4'd1;
                  end
               end
            end
            ST_RACK: begin
               if (ev.scl_rise) begin
                  mack_q <= ~ev.sda;
               end else if (ev.scl_fall) begin
                  bitcnt <= '0;
                  if (mack_q) begin
                     tx_sh <= rd_data;
                     oe_q  <= ~rd_data[7];
                     ptr   <= ptr + 1'b1;
                     state <= ST_RDATA;
                  end else begin
                     state <= ST_IGNORE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ev.stop |=> !sda_oe);

   assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> !sda_oe);

   assert_drive_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !ev.scl);

   assert_read_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_load |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

   assert_rack_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK) |-> !sda_oe);

   if (PAGE_W < ADDR_W) begin : g_page_chk
      assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
   end

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
   import i2c_mem_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h50,
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_W      = 4,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W must lie in 1..8 for a one-byte address phase");
   end
   if (PAGE_W < 1 || PAGE_W > ADDR_W) begin : g_bad_page
      $error("PAGE_W must lie in 1..ADDR_W");
   end

   bus_ev_t           ev;
   logic [ADDR_W-1:0] ptr;
   logic              wr_en;
   logic [7:0]        wr_data;
   logic [7:0]        rd_data;

   i2c_bus_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev    (ev)
   );

   i2c_mem_ctrl #(
      .DEV_ADDR (DEV_ADDR),
      .ADDR_W   (ADDR_W),
      .PAGE_W   (PAGE_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev),
      .rd_data (rd_data),
      .ptr_o   (ptr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .sda_oe  (sda_oe)
   );

   i2c_mem_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (8),
      .ERASED (8'hFF)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (ptr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data)
   );

endmodule

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;

   localparam int         CLK_PERIOD = 10;
   localparam int         Q          = 8;
   localparam logic [6:0] DEV        = 7'h50;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_oe;
   logic sda_line;

   assign sda_line = m_sda & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_mem_slave dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (m_scl),
      .sda_i  (sda_line),
      .sda_oe (sda_oe)
   );

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   logic [7:0] ref_mem [256];
   logic [7:0] ref_ptr;
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] act_q [$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         while (act_q.size() > 0 && exp_q.size() > 0) begin
            check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
         end
      end
   end

   task automatic bus_start();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(Q);
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic recv_bit(output logic b);
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      b = sda_line; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic wr_byte(input logic [7:0] d, output bit acked);
      logic x;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(x);
      acked = (x == 1'b0);
   endtask

   task automatic rd_byte(input bit mack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) recv_bit(d[i]);
      m_sda = ~mack; tick(Q);
      m_scl = 1'b1; tick(Q);
      check("R10 released in ack clock", sda_oe, 1'b0);
      tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic m_write(input logic [7:0] addr, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
      bit a;
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      bus_start();
      wr_byte({DEV, 1'b0}, a); check("R2 write address ack", a, 1'b1);
      wr_byte(addr, a);        check("R3 byte address ack", a, 1'b1);
      ref_ptr = addr;
      for (int k = 0; k < n; k++) begin
         wr_byte(d[k], a);     check("R3 data ack", a, 1'b1);
         ref_mem[ref_ptr] = d[k];
         ref_ptr = {ref_ptr[7:4], 4'(ref_ptr[3:0] + 4'd1)};
      end
      bus_stop();
   endtask

   task automatic m_read(input bit rnd, input logic [7:0] addr, input int n, input string req);
      bit a;
      logic [7:0] d;
      bus_start();
      if (rnd) begin
         wr_byte({DEV, 1'b0}, a); check("R2 dummy write ack", a, 1'b1);
         wr_byte(addr, a);        check("R6 byte address ack", a, 1'b1);
         ref_ptr = addr;
         bus_start();
      end
      wr_byte({DEV, 1'b1}, a); check("R2 read address ack", a, 1'b1);
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(ref_mem[ref_ptr]);
         tag_q.push_back(req);
         ref_ptr = ref_ptr + 8'd1;
         rd_byte(k < n - 1, d);
         act_q.push_back(d);
      end
      bus_stop();
      tick(4);
      check("R9 released after stop", sda_oe, 1'b0);
   endtask

   initial begin
      bit a;
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
      ref_ptr = 8'h00;
      tick(5);
      check("R1 sda released in reset", sda_oe, 1'b0);
      rst_n = 1'b1;
      tick(5);
      check("R1 sda released after reset", sda_oe, 1'b0);

      m_read(1'b0, 8'h00, 1, "R1 erased byte");
      m_read(1'b1, 8'h80, 2, "R1 erased bytes");

      m_write(8'h20, 3, 8'hA1, 8'hB2, 8'hC3);
      m_read(1'b1, 8'h20, 1, "R6 random read");

      // mismatched address: no ack, bytes that follow are ignored
      bus_start();
      wr_byte({7'h51, 1'b0}, a); check("R2 mismatch not acked", a, 1'b0);
      wr_byte(8'h21, a);         check("R2 ignored byte not acked", a, 1'b0);
      wr_byte(8'hEE, a);         check("R2 ignored byte not acked", a, 1'b0);
      bus_stop();

      m_read(1'b0, 8'h00, 2, "R5 current read after mismatch");

      m_write(8'h1E, 3, 8'h11, 8'h22, 8'h33);
      m_read(1'b1, 8'h10, 1, "R4 page wrap write");
      m_read(1'b1, 8'h1E, 3, "R7 sequential across page");

      m_write(8'hFF, 2, 8'h5A, 8'h6B, 8'h00);
      m_write(8'h00, 1, 8'h7C, 8'h00, 8'h00);
      m_read(1'b1, 8'hF0, 1, "R4 wrap at top page");
      m_read(1'b1, 8'hFF, 2, "R8 end-of-memory wrap");
      m_read(1'b0, 8'h00, 1, "R5 current read after wrap");
      m_read(1'b0, 8'h00, 1, "R9 start after stop");

      tick(20);
      while (act_q.size() > 0) tick(1);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R9: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule